// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address stream for a four-beat memory burst. A burst begins when either of two active-low address strobes is sampled. One is the processor strobe, which counts only while the first chip enable is active. The other is the controller strobe, which counts whatever that enable is doing. The sampled address becomes the base of the burst. After that, each sampled advance request moves the two lowest address bits to the next beat. The upper bits stay frozen until the next load.

A mode input chooses the order of the beats. In linear order the low bits count up modulo four from the loaded value. In interleaved order the low bits are the loaded value XORed with the beat number. Every control input is captured in an input register. The address output comes from a second register stage, so any input takes effect on the output two clock edges after it is presented. The output drives the row and column decode of a memory core.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the output register clears. After reset releases, `addr_out` reads 0 until the first load.
- R2: A load sampled at clock edge k (`ctrl_strobe_n` low, or `proc_strobe_n` low with `ce1_n` low) makes `addr_out` equal the `addr_in` value sampled at edge k, from edge k+1 onward.
- R3: With `order_linear` = 1 (linear), the low two bits after n advances are (start + n) mod 4. For example, start 2 gives 2, 3, 0, 1.
- R4: With `order_linear` = 0 (interleaved), the low two bits after n advances are start XOR (n mod 4). For example, start 1 gives 1, 0, 3, 2, and start 3 gives 3, 2, 1, 0.
- R5: An `advance_n` low sampled at edge k, with no load, steps the beat at edge k+1. With neither a load nor an advance, `addr_out` holds.
- R6: The beat count wraps, so four advances return the low bits to the loaded start value.
- R7: `proc_strobe_n` low while `ce1_n` is high is ignored. `addr_out` keeps its value.
- R8: `ctrl_strobe_n` low loads the address whatever the value of `ce1_n`.
- R9: Strobes win over advance. A load and an advance in the same cycle produce a load at beat 0. When both strobes are low and `ce1_n` is low, the processor strobe is the source of the load.
- R10: A change of `order_linear` sampled at edge k re-orders the current beat on `addr_out` at edge k+1, with no advance needed.
- R11: Between loads, `addr_out` bits above bit 1 never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W (19) | Base address for a new burst |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, ungated |
| ce1_n | input | 1 | First chip enable, active low |
| advance_n | input | 1 | Advance to the next beat, active low |
| order_linear | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_out | output | ADDR_W (19) | Current burst address |

## Verification
The main function is run under several patterns:
- A linear burst from start 2 and interleaved bursts from starts 1 and 3. The different starts separate add-with-wrap from XOR, since the two orders agree at start 0.
- Four full advances followed by idle cycles. These show the wrap of the beat count and the hold.
- Strobe patterns that set the processor strobe against the chip enable and against the controller strobe, with an advance issued together with a load. These expose a wrong gate, a wrong priority, or a wrong precedence of advance over load.
- A mode flip in the middle of a burst with no advance. This shows whether order is applied at the output stage with the stated one-cycle delay.

A behavioural model in the bench follows every cycle, so timing slips of one edge are also caught.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Width of the in-burst beat counter: four beats per burst.
    localparam int BURST_CNT_W = 2;
    localparam int BURST_BEATS = 1 << BURST_CNT_W;

    typedef enum logic {
        ORDER_INTERLEAVE = 1'b0,
        ORDER_LINEAR     = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } load_src_e;

    // Registered control word handed from the input stage to the counter.
    typedef struct packed {
        logic      load;
        load_src_e src;
        logic      adv;
        order_e    order;
    } seq_ctl_t;

    // Priority decode of the two strobes; processor strobe first, gated by enable.
    function automatic load_src_e pick_source(logic proc_n, logic ctrl_n, logic ce_n);
        if (!proc_n && !ce_n) return SRC_PROC;
        if (!ctrl_n)          return SRC_CTRL;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/burst_in_stage.sv
module burst_in_stage
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              ce1_n,
    input  logic              advance_n,
    input  logic              order_linear,
    output seq_ctl_t          ctl_q,
    output logic [ADDR_W-1:0] addr_q
);

    seq_ctl_t ctl_d;

    always_comb begin
        ctl_d.src   = pick_source(proc_strobe_n, ctrl_strobe_n, ce1_n);
        ctl_d.load  = (ctl_d.src != SRC_NONE);
        ctl_d.adv   = !advance_n;
        ctl_d.order = order_e'(order_linear);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{load: 1'b0, src: SRC_NONE, adv: 1'b0, order: ORDER_INTERLEAVE};
            addr_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            addr_q <= addr_in;
        end
    end

    // R7: gated processor strobe alone never registers a load
    p_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && ce1_n && ctrl_strobe_n) |=> !ctl_q.load);

    // R8: controller strobe always registers a load
    p_ctrl_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_strobe_n |=> ctl_q.load);

    // R9: an enabled processor strobe is the chosen source
    p_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !ce1_n) |=> (ctl_q.src == SRC_PROC));

endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = BURST_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl_q,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  beat,
    output order_e            order_r
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base    <= '0;
            beat    <= '0;
            order_r <= ORDER_INTERLEAVE;
        end else begin
            order_r <= ctl_q.order;
            if (ctl_q.load) begin
                base <= addr_q;
                beat <= '0;
            end else if (ctl_q.adv) begin
                beat <= beat + CNT_W'(1);
            end
        end
    end

    // R2: a registered load takes the base and restarts the beat
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_q.load |=> (base == $past(addr_q) && beat == '0));

    // R5: advance without load steps the beat by one (wrapping, R6)
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.load && ctl_q.adv) |=> (beat == $past(beat) + CNT_W'(1)));

    // R5: idle cycles hold the burst state
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.load && !ctl_q.adv) |=> ($stable(beat) && $stable(base)));

    // R9: every load carries a named source
    p_src_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_q.load |-> (ctl_q.src != SRC_NONE));

endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = BURST_CNT_W
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    input  order_e           order,
    output logic [CNT_W-1:0] low
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    assign lin_low = start + beat;

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_low[b] = start[b] ^ beat[b];
    end

    assign low = (order == ORDER_LINEAR) ? lin_low : ilv_low;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              ce1_n,
    input  logic              advance_n,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int CNT_W = BURST_CNT_W;

    seq_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  beat;
    logic [CNT_W-1:0]  low;
    order_e            order_r;

    burst_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr_in),
        .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n),
        .ce1_n        (ce1_n),
        .advance_n    (advance_n),
        .order_linear (order_linear),
        .ctl_q        (ctl_q),
        .addr_q       (addr_q)
    );

    burst_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ctl_q  (ctl_q),
        .addr_q (addr_q),
        .base   (base),
        .beat   (beat),
        .order_r(order_r)
    );

    burst_order #(.CNT_W(CNT_W)) u_ord (
        .start(base[CNT_W-1:0]),
        .beat (beat),
        .order(order_r),
        .low  (low)
    );

    assign addr_out = {base[ADDR_W-1:CNT_W], low};

    // R11: upper address bits frozen between loads
    p_upper_r11: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.load |=> $stable(addr_out[ADDR_W-1:CNT_W]));

endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int AW = 19;
    localparam time TCLK = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          ce1_n = 1'b1;
    logic          advance_n = 1'b1;
    logic          order_linear = 1'b0;
    logic [AW-1:0] addr_out;

    int    n_checks = 0;
    int    n_err    = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    always #(TCLK/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .ce1_n(ce1_n), .advance_n(advance_n), .order_linear(order_linear),
        .addr_out(addr_out)
    );

    // Behavioural reference: inputs seen at one edge, output formed at the next.
    int s_ld, s_addr, s_adv, s_ord;
    int m_base, m_beat, m_ord;

    always @(posedge clk) begin
        if (rst) begin
            s_ld = 0; s_addr = 0; s_adv = 0; s_ord = 0;
            m_base = 0; m_beat = 0; m_ord = 0;
        end else begin
            m_ord = s_ord;
            if (s_ld != 0) begin
                m_base = s_addr;
                m_beat = 0;
            end else if (s_adv != 0) begin
                m_beat = (m_beat + 1) % 4;
            end
            s_ld   = ((!proc_strobe_n && !ce1_n) || !ctrl_strobe_n) ? 1 : 0;
            s_addr = int'(addr_in);
            s_adv  = advance_n ? 0 : 1;
            s_ord  = order_linear ? 1 : 0;
        end
    end

    function automatic int model_addr();
        int lo;
        lo = (m_ord != 0) ? (((m_base & 3) + m_beat) % 4) : ((m_base & 3) ^ m_beat);
        return (m_base & ~3) | lo;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (int'(addr_out) != model_addr()) begin
                n_err++;
                $display("FAIL model %s: addr_out=%h expected %h", cur_req, addr_out, model_addr());
            end
        end
    end

    // Set inputs at a falling edge, return at the next falling edge.
    task automatic drv(input bit p, input bit c, input bit e, input bit a,
                       input bit lin, input logic [AW-1:0] ad);
        proc_strobe_n = p; ctrl_strobe_n = c; ce1_n = e;
        advance_n = a; order_linear = lin; addr_in = ad;
        @(negedge clk);
    endtask

    task automatic idle(input bit lin);
        drv(1, 1, 1, 1, lin, 19'h7FFFF);
    endtask

    task automatic chk(input logic [AW-1:0] exp, input string tag);
        n_checks++;
        if (addr_out !== exp) begin
            n_err++;
            $display("FAIL %s: addr_out=%h expected %h", tag, addr_out, exp);
        end
    endtask

    initial begin
        #(TCLK * 100000);
        n_err++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) idle(0);
        rst = 1'b0;
        idle(0);
        chk('0, "R1 reset value");
        idle(0);
        chk('0, "R1 reset hold");

        // R2 R3 R6 R11: linear burst from start 2
        cur_req = "R3";
        drv(1, 0, 1, 1, 1, 19'h5A3C2);
        drv(1, 1, 1, 0, 1, 19'h00000);
        chk(19'h5A3C2, "R2 load latency");
        drv(1, 1, 1, 0, 1, 19'h00001);
        chk(19'h5A3C3, "R3 linear beat1");
        drv(1, 1, 1, 0, 1, 19'h00002);
        chk(19'h5A3C0, "R3 linear beat2 wrap, R11 upper");
        drv(1, 1, 1, 0, 1, 19'h00003);
        chk(19'h5A3C1, "R3 linear beat3");
        idle(1);
        chk(19'h5A3C2, "R6 four advances return to start");
        idle(1);
        chk(19'h5A3C2, "R5 hold without advance");

        // R4: interleaved from start 1
        cur_req = "R4";
        drv(0, 1, 0, 1, 0, 19'h12341);
        drv(1, 1, 1, 0, 0, 19'h0);
        chk(19'h12341, "R4 interleave start1 beat0");
        drv(1, 1, 1, 0, 0, 19'h0);
        chk(19'h12340, "R4 interleave start1 beat1");
        drv(1, 1, 1, 0, 0, 19'h0);
        chk(19'h12343, "R4 interleave start1 beat2");
        idle(0);
        chk(19'h12342, "R4 interleave start1 beat3");

        // R4: interleaved from start 3
        drv(1, 0, 1, 1, 0, 19'h6ABC7);
        drv(1, 1, 1, 0, 0, 19'h0);
        chk(19'h6ABC7, "R4 interleave start3 beat0");
        drv(1, 1, 1, 0, 0, 19'h0);
        chk(19'h6ABC6, "R4 interleave start3 beat1");
        drv(1, 1, 1, 0, 0, 19'h0);
        chk(19'h6ABC5, "R4 interleave start3 beat2");
        idle(0);
        chk(19'h6ABC4, "R4 interleave start3 beat3");

        // R7: processor strobe with enable inactive is ignored
        cur_req = "R7";
        drv(0, 1, 1, 1, 0, 19'h33333);
        idle(0);
        chk(19'h6ABC4, "R7 gated strobe ignored");
        idle(0);
        chk(19'h6ABC4, "R7 gated strobe ignored later");

        // R8: controller strobe loads with enable inactive
        cur_req = "R8";
        drv(1, 0, 1, 1, 0, 19'h44442);
        idle(0);
        chk(19'h44442, "R8 controller strobe ungated");

        // R9: both strobes plus advance, enable inactive then active
        cur_req = "R9";
        drv(1, 1, 1, 0, 0, 19'h0);
        drv(0, 0, 1, 0, 0, 19'h55551);
        chk(19'h44443, "R9 pre-advance");
        idle(0);
        chk(19'h55551, "R9 load wins over advance");
        drv(0, 0, 0, 0, 1, 19'h26662);
        idle(1);
        chk(19'h26662, "R9 both strobes enabled single load");

        // R10: order switch mid-burst without advance
        cur_req = "R10";
        drv(1, 0, 1, 1, 1, 19'h71111);
        drv(1, 1, 1, 0, 1, 19'h0);
        chk(19'h71111, "R10 load");
        idle(1);
        chk(19'h71112, "R10 linear beat1");
        idle(0);
        chk(19'h71112, "R10 order not yet applied");
        idle(0);
        chk(19'h71110, "R10 interleaved beat1 after switch");
        idle(1);
        idle(1);
        chk(19'h71112, "R10 back to linear");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule